// File: doc/BRIEF.md
# Configuration Command Table Engine

This block runs a list of register-configuration commands that a host has placed in shared memory. The host first writes the table's base address into a pointer register. It then writes the number of entries into a length register, and that write starts the run. The engine reads each entry through a single-outstanding memory read port.

For every configuration-write entry, the engine reads a data word from shared memory and places it on an internal register write port. While the run is in progress, the host can read the length register to see how many entries are still waiting. When that count reaches zero, the host may load a new table.

The engine raises a one-clock acknowledge for each finished entry that asks for one, and a one-clock end-of-command pulse when the final entry of the table completes. Alongside the table engine, a separate watcher flags a port whose serial clock has been silent for a configurable number of system clocks.

Top module: `cfg_cmd_engine`

## Requirements
- R1: A host write with `host_sel`=0 loads the table base. Entry i is then read as two words: the command word at base+8*i and the pointer word at base+8*i+4.
- R2: A host write with `host_sel`=1 while `len_pending` is 0 loads `len_pending` from the data on the next clock edge. If the loaded value is nonzero, the table starts running from the base.
- R3: `len_pending` drops by exactly one as each entry finishes, never rises while it is nonzero, and reads 0 when the table is done.
- R4: A command word with opcode 0x1 in bits [31:28] is a configuration write. The engine reads the word at the address held in the pointer word, then pulses `reg_wr_en` for one clock with `reg_wr_addr` equal to command bits [15:0] and `reg_wr_data` equal to the word it read.
- R5: `ack_pulse` is high in the same cycle as `reg_wr_en` when command bit 27 is 1. It stays low for entries with bit 27 clear.
- R6: `eoc_pulse` is high for one clock when the last entry of a table finishes, and `len_pending` is 0 on the following cycle.
- R7: An entry whose opcode is not 0x1 produces no register write and no acknowledge. It still decrements `len_pending` and sets the sticky `err_opcode` flag.
- R8: A length write while `len_pending` is nonzero leaves the count and the run unchanged and sets the sticky `err_overrun` flag.
- R9: `mem_req` is a one-clock request with `mem_addr`. No new request is issued until `mem_valid` returns the data for the previous one.
- R10: `no_sclk` goes high once `port_sclk` has shown no edge for 16 system clocks (the default). It returns low a few clocks after an edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host direct write strobe |
| host_sel | input | 1 | 0 = table base, 1 = table length |
| host_wdata | input | 32 | Host write data |
| len_pending | output | 16 | Entries still waiting to run |
| mem_req | output | 1 | Shared-memory read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| reg_wr_en | output | 1 | Internal register write strobe |
| reg_wr_addr | output | 16 | Internal register address |
| reg_wr_data | output | 32 | Internal register value |
| ack_pulse | output | 1 | Per-entry acknowledge interrupt |
| eoc_pulse | output | 1 | End of table indication |
| err_opcode | output | 1 | Sticky unknown-opcode flag |
| err_overrun | output | 1 | Sticky ignored-length-write flag |
| port_sclk | input | 1 | Serial clock of the watched port |
| no_sclk | output | 1 | Port serial clock absent |

## Verification
A length write is registered on the next edge, so the bench reads `len_pending` and `err_overrun` at the falling edge after that edge.

Each register write and its acknowledge come out together in the cycle after the data word arrives. A scoreboard monitor samples `reg_wr_en`, `ack_pulse` and `eoc_pulse` at every falling edge, so it compares each event in the cycle it occurs.

The clock-absence flag passes through a two-stage synchronizer and an edge detector. The bench therefore lets a little more than 16 clocks of silence pass before expecting it high, and several clocks after a toggle before expecting it low.

// File: rtl/cfgq_pkg.sv
package cfgq_pkg;
   localparam logic [3:0] OP_CFG_WR = 4'h1;
   localparam int         OP_MSB    = 31;
   localparam int         OP_LSB    = 28;
   localparam int         ACK_BIT   = 27;

   typedef enum logic [3:0] {
      S_IDLE,
      S_REQ_CMD,
      S_WAIT_CMD,
      S_REQ_PTR,
      S_WAIT_PTR,
      S_REQ_DAT,
      S_WAIT_DAT,
      S_WRITE,
      S_SKIP
   } seq_state_t;
endpackage

// File: rtl/cfgq_ctrl_regs.sv
module cfgq_ctrl_regs #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int HOST_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [HOST_W-1:0] host_wdata,
   input  logic              entry_done,
   input  logic              op_err_set,
   output logic [ADDR_W-1:0] base_addr,
   output logic [LEN_W-1:0]  count,
   output logic              start,
   output logic              err_opcode,
   output logic              err_overrun
);
   logic len_wr;
   logic idle_cnt;

   assign len_wr   = host_wr && host_sel;
   assign idle_cnt = (count == '0);
   assign start    = len_wr && idle_cnt && (host_wdata[LEN_W-1:0] != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr   <= '0;
         count       <= '0;
         err_opcode  <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (host_wr && !host_sel)
            base_addr <= host_wdata[ADDR_W-1:0];
         if (len_wr && idle_cnt)
            count <= host_wdata[LEN_W-1:0];
         else if (entry_done && !idle_cnt)
            count <= count - 1'b1;
         if (len_wr && !idle_cnt)
            err_overrun <= 1'b1;
         if (op_err_set)
            err_opcode <= 1'b1;
      end
   end
endmodule

// File: rtl/cfgq_seq.sv
module cfgq_seq
   import cfgq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int RADDR_W = 16,
   parameter int LEN_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [LEN_W-1:0]   count,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_valid,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               reg_wr_en,
   output logic [RADDR_W-1:0] reg_wr_addr,
   output logic [DATA_W-1:0]  reg_wr_data,
   output logic               ack_pulse,
   output logic               eoc_pulse,
   output logic               entry_done,
   output logic               op_err_set
);
   localparam int ENTRY_BYTES = 8;
   localparam int PTR_OFS     = 4;

   seq_state_t         state, state_nx;
   logic [ADDR_W-1:0]  cursor;
   logic [DATA_W-1:0]  cmd_q;
   logic [ADDR_W-1:0]  ptr_q;
   logic [DATA_W-1:0]  dat_q;
   logic               last_entry;
   logic               cmd_is_wr;

   assign last_entry = (count == {{(LEN_W-1){1'b0}}, 1'b1});
   assign cmd_is_wr  = (mem_rdata[OP_MSB:OP_LSB] == OP_CFG_WR);

   always_comb begin
      state_nx = state;
      unique case (state)
         S_IDLE:     if (start) state_nx = S_REQ_CMD;
         S_REQ_CMD:  state_nx = S_WAIT_CMD;
         S_WAIT_CMD: if (mem_valid) state_nx = cmd_is_wr ? S_REQ_PTR : S_SKIP;
         S_REQ_PTR:  state_nx = S_WAIT_PTR;
         S_WAIT_PTR: if (mem_valid) state_nx = S_REQ_DAT;
         S_REQ_DAT:  state_nx = S_WAIT_DAT;
         S_WAIT_DAT: if (mem_valid) state_nx = S_WRITE;
         S_WRITE,
         S_SKIP:     state_nx = last_entry ? S_IDLE : S_REQ_CMD;
         default:    state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cursor <= '0;
         cmd_q  <= '0;
         ptr_q  <= '0;
         dat_q  <= '0;
      end else begin
         state <= state_nx;
         if (state == S_IDLE && start)
            cursor <= base_addr;
         else if (state == S_WRITE || state == S_SKIP)
            cursor <= cursor + ADDR_W'(ENTRY_BYTES);
         if (state == S_WAIT_CMD && mem_valid) cmd_q <= mem_rdata;
         if (state == S_WAIT_PTR && mem_valid) ptr_q <= mem_rdata[ADDR_W-1:0];
         if (state == S_WAIT_DAT && mem_valid) dat_q <= mem_rdata;
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = '0;
      unique case (state)
         S_REQ_CMD: begin mem_req = 1'b1; mem_addr = cursor; end
         S_REQ_PTR: begin mem_req = 1'b1; mem_addr = cursor + ADDR_W'(PTR_OFS); end
         S_REQ_DAT: begin mem_req = 1'b1; mem_addr = ptr_q; end
         default:   ;
      endcase
   end

   assign reg_wr_en   = (state == S_WRITE);
   assign reg_wr_addr = cmd_q[RADDR_W-1:0];
   assign reg_wr_data = dat_q;
   assign ack_pulse   = reg_wr_en && cmd_q[ACK_BIT];
   assign entry_done  = (state == S_WRITE) || (state == S_SKIP);
   assign eoc_pulse   = entry_done && last_entry;
   assign op_err_set  = (state == S_SKIP);
endmodule

// File: rtl/cfgq_clk_watch.sv
module cfgq_clk_watch #(
   parameter int TIMEOUT = 16,
   parameter int STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic port_sclk,
   output logic no_sclk
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

   logic             sclk_s;
   logic             sclk_d;
   logic             edge_seen;
   logic [CNT_W-1:0] quiet_cnt;

   if (STAGES == 0) begin : g_nosync
      assign sclk_s = port_sclk;
   end else begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0:0], port_sclk};
      end
      assign sclk_s = chain[STAGES-1];
   end

   assign edge_seen = sclk_s ^ sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         quiet_cnt <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (edge_seen)
            quiet_cnt <= '0;
         else if (quiet_cnt != LIMIT)
            quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   assign no_sclk = (quiet_cnt == LIMIT);
endmodule

// File: rtl/cfg_cmd_engine.sv
module cfg_cmd_engine #(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int RADDR_W      = 16,
   parameter int LEN_W        = 16,
   parameter int SCLK_TIMEOUT = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic               host_sel,
   input  logic [31:0]        host_wdata,
   output logic [LEN_W-1:0]   len_pending,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_valid,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               reg_wr_en,
   output logic [RADDR_W-1:0] reg_wr_addr,
   output logic [DATA_W-1:0]  reg_wr_data,
   output logic               ack_pulse,
   output logic               eoc_pulse,
   output logic               err_opcode,
   output logic               err_overrun,
   input  logic               port_sclk,
   output logic               no_sclk
);
   localparam int HOST_W = 32;

   if (ADDR_W > HOST_W || ADDR_W > DATA_W || ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be 4..32 and not wider than DATA_W");
   end
   if (LEN_W < 1 || LEN_W > HOST_W) begin : g_bad_len
      $error("LEN_W must be 1..32");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("command word layout needs DATA_W of 32");
   end
   if (RADDR_W < 1 || RADDR_W > 16) begin : g_bad_raddr
      $error("RADDR_W must be 1..16");
   end
   if (SCLK_TIMEOUT < 1 || SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_watch
      $error("clock watcher parameters out of range");
   end

   logic [ADDR_W-1:0] base_addr;
   logic              start;
   logic              entry_done;
   logic              op_err_set;

   cfgq_ctrl_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .HOST_W(HOST_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_sel    (host_sel),
      .host_wdata  (host_wdata),
      .entry_done  (entry_done),
      .op_err_set  (op_err_set),
      .base_addr   (base_addr),
      .count       (len_pending),
      .start       (start),
      .err_opcode  (err_opcode),
      .err_overrun (err_overrun)
   );

   cfgq_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RADDR_W(RADDR_W), .LEN_W(LEN_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .base_addr   (base_addr),
      .count       (len_pending),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .mem_valid   (mem_valid),
      .mem_rdata   (mem_rdata),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_addr (reg_wr_addr),
      .reg_wr_data (reg_wr_data),
      .ack_pulse   (ack_pulse),
      .eoc_pulse   (eoc_pulse),
      .entry_done  (entry_done),
      .op_err_set  (op_err_set)
   );

   cfgq_clk_watch #(.TIMEOUT(SCLK_TIMEOUT), .STAGES(SYNC_STAGES)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_sclk (port_sclk),
      .no_sclk   (no_sclk)
   );
endmodule

// File: rtl/cfgq_checker.sv
module cfgq_checker #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LEN_W-1:0] len_pending,
   input logic             mem_req,
   input logic             reg_wr_en,
   input logic             ack_pulse,
   input logic             eoc_pulse,
   input logic             err_opcode,
   input logic             err_overrun
);
   // R4
   wr_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (len_pending != '0));
   // R5
   ack_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_pulse |-> reg_wr_en);
   // R6
   eoc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_pulse |=> (len_pending == '0));
   // R9
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R3
   no_count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_pending != '0) |=> (len_pending <= $past(len_pending)));
   // R7
   opcode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_opcode |=> err_opcode);
   // R8
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun |=> err_overrun);
endmodule

bind cfg_cmd_engine cfgq_checker #(.LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .len_pending (len_pending),
   .mem_req     (mem_req),
   .reg_wr_en   (reg_wr_en),
   .ack_pulse   (ack_pulse),
   .eoc_pulse   (eoc_pulse),
   .err_opcode  (err_opcode),
   .err_overrun (err_overrun)
);

// File: tb/tb_cfg_cmd_engine.sv
`timescale 1ns/1ps
module tb_cfg_cmd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [15:0] len_pending;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        reg_wr_en;
   logic [15:0] reg_wr_addr;
   logic [31:0] reg_wr_data;
   logic        ack_pulse, eoc_pulse, err_opcode, err_overrun;
   logic        port_sclk = 1'b0;
   logic        no_sclk;

   int checks = 0;
   int errors = 0;
   int eoc_cnt = 0;
   int ack_cnt = 0;

   typedef struct packed {
      logic [15:0] a;
      logic [31:0] d;
      logic        k;
   } exp_t;
   exp_t exp_q[$];

   logic [31:0] mem [0:255];
   logic        pend = 1'b0;
   logic [31:0] paddr = '0;

   always #2 clk = ~clk;

   cfg_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .len_pending(len_pending), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .ack_pulse(ack_pulse), .eoc_pulse(eoc_pulse), .err_opcode(err_opcode),
      .err_overrun(err_overrun), .port_sclk(port_sclk), .no_sclk(no_sclk)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // shared memory model: answers each request one cycle later
   always @(negedge clk) begin
      mem_valid <= 1'b0;
      if (pend) begin
         mem_valid <= 1'b1;
         mem_rdata <= mem[paddr[9:2]];
         pend      <= 1'b0;
      end
      if (mem_req) begin
         pend  <= 1'b1;
         paddr <= mem_addr;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr_en) begin
            if (exp_q.size() == 0) begin
               check("R7 unexpected write", {16'h0, reg_wr_addr, reg_wr_data}, 64'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R4 write addr", 64'(reg_wr_addr), 64'(e.a));
               check("R4 write data", 64'(reg_wr_data), 64'(e.d));
               check("R5 ack with write", 64'(ack_pulse), 64'(e.k));
            end
         end else if (ack_pulse) begin
            check("R5 ack without write", 64'(ack_pulse), 64'h0);
         end
         if (ack_pulse) ack_cnt++;
         if (eoc_pulse) eoc_cnt++;
      end
   end

   task automatic host_write(input logic sel, input logic [31:0] v);
      @(negedge clk);
      host_wr <= 1'b1; host_sel <= sel; host_wdata <= v;
      @(negedge clk);
      host_wr <= 1'b0;
   endtask

   task automatic push_exp(input logic [15:0] a, input logic [31:0] d, input logic k);
      exp_t e;
      e.a = a; e.d = d; e.k = k;
      exp_q.push_back(e);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 400 && len_pending != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      // table A at 0x40: 4 entries
      mem[16] = 32'h1800_0012; mem[17] = 32'h0000_0200;
      mem[18] = 32'h1000_0034; mem[19] = 32'h0000_0204;
      mem[20] = 32'h7800_00FF; mem[21] = 32'h0000_0210;
      mem[22] = 32'h1800_0056; mem[23] = 32'h0000_0208;
      mem[128] = 32'hA5A5_0001;
      mem[129] = 32'h1234_5678;
      mem[130] = 32'hDEAD_BEEF;
      mem[132] = 32'hFFFF_FFFF;
      // table B at 0x100: 1 entry
      mem[64] = 32'h1000_0077; mem[65] = 32'h0000_020C;
      mem[131] = 32'h0BAD_F00D;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 reset count", 64'(len_pending), 64'h0);
      check("R9 reset no request", 64'(mem_req), 64'h0);
      check("R7 reset err_opcode", 64'(err_opcode), 64'h0);
      check("R8 reset err_overrun", 64'(err_overrun), 64'h0);
      check("R10 reset no_sclk", 64'(no_sclk), 64'h0);

      // table A (R1 R2 R4 R5 R7)
      push_exp(16'h0012, 32'hA5A5_0001, 1'b1);
      push_exp(16'h0034, 32'h1234_5678, 1'b0);
      push_exp(16'h0056, 32'hDEAD_BEEF, 1'b1);
      host_write(1'b0, 32'h0000_0040);
      host_write(1'b1, 32'd4);
      check("R2 count loaded", 64'(len_pending), 64'd4);
      host_write(1'b1, 32'd7);
      check("R8 overrun flag", 64'(err_overrun), 64'h1);
      check("R8 count not reloaded", 64'(len_pending <= 16'd4), 64'h1);
      wait_done();
      check("R3 count done", 64'(len_pending), 64'h0);
      check("R7 err_opcode set", 64'(err_opcode), 64'h1);
      check("R1 all writes seen", 64'(exp_q.size()), 64'h0);
      check("R5 ack count", 64'(ack_cnt), 64'd2);
      check("R6 eoc once", 64'(eoc_cnt), 64'd1);

      // table B at new base (R1 R2 R6)
      push_exp(16'h0077, 32'h0BAD_F00D, 1'b0);
      host_write(1'b0, 32'h0000_0100);
      host_write(1'b1, 32'd1);
      check("R2 second load", 64'(len_pending), 64'd1);
      check("R8 second load no new overrun effect", 64'(err_overrun), 64'h1);
      wait_done();
      check("R1 table B write seen", 64'(exp_q.size()), 64'h0);
      check("R6 eoc second table", 64'(eoc_cnt), 64'd2);
      check("R5 no extra ack", 64'(ack_cnt), 64'd2);

      // serial clock watcher (R10): silent since reset
      repeat (20) @(negedge clk);
      check("R10 absent clock flagged", 64'(no_sclk), 64'h1);
      for (int i = 0; i < 10; i++) begin
         port_sclk = ~port_sclk;
         repeat (4) @(negedge clk);
      end
      check("R10 active clock clears", 64'(no_sclk), 64'h0);
      repeat (10) @(negedge clk);
      check("R10 not yet timed out", 64'(no_sclk), 64'h0);
      repeat (12) @(negedge clk);
      check("R10 timeout again", 64'(no_sclk), 64'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule